// File: doc/BRIEF.md
# Fall-Through FIFO Stack Core

This block is the middle section of a first-in first-out buffer: a chain of 62 four-bit storage locations, each with its own occupancy flag. An input register at the top offers a word. When the top location is free, the word is captured. It then moves one location toward the bottom on every clock edge for which the next location is free, or is being freed on that same edge. Words therefore collect at the bottom in arrival order, with no read or write pointers.

An output register at the bottom reads the bottom word and asks for it with a load request. A word leaves the stack exactly once. A full column of words shifts down as one whenever the bottom word is taken.

Two status outputs serve the neighbouring registers. One says that the top location can accept a word. The other says that a word is waiting at the bottom. Reset clears only the occupancy flags. The stored data bits keep their values.

Top module: `ft_stack_core`

## Requirements
- R1: While reset is applied, and after its synchronised release, `bot_valid` is 0. `top_empty` is 0 while reset is active and 1 once the release has passed two rising edges of the clock.
- R2: A word on `wr_data` is captured on a rising edge at which `wr_req` is 1 and `top_empty` is 1. After that edge, `top_empty` is 0.
- R3: A write request made while `top_empty` is 0 is ignored. No word is added to the stack.
- R4: A word captured into an empty stack sets `bot_valid` after the 62nd rising edge, counting the capturing edge as the first. `bot_valid` stays 0 before that edge.
- R5: In a full stack with `rd_req` held at 1, the words shift down together. `bot_valid` stays 1 for 62 consecutive pops.
- R6: The stack holds exactly DEPTH (62) words. With no pops, continuous write requests are accepted exactly 62 times, and `top_empty` then stays 0.
- R7: A pop takes place on a rising edge at which `rd_req` and `bot_valid` are both 1. Each word is delivered once. While `bot_valid` is 1 and `rd_req` is 0, `bot_valid` and `bot_data` hold.
- R8: Under any mix of concurrent writes, pops and stalls, words leave in the order they were accepted, with none lost and none duplicated.
- R9: Reset leaves the data bits of every location unchanged. The word last held at the bottom is still present on `bot_data` after reset, while `bot_valid` is 0.
- R10: `rd_req` asserted while `bot_valid` is 0 has no effect. A word that arrives later is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_req | input | 1 | Input register holds a word for the stack |
| wr_data | input | 4 | Word offered at the top |
| top_empty | output | 1 | Top location free; a write is accepted this cycle |
| rd_req | input | 1 | Output register requests the bottom word |
| bot_valid | output | 1 | A word is present at the bottom location |
| bot_data | output | 4 | Word at the bottom location |

## Verification
The bench times a single word through the empty stack and checks that `bot_valid` rises on the 62nd edge exactly. A design with an extra register, or with a stage that skips ahead, misses that edge. It fills the stack with writes held high and checks that exactly 62 are accepted. A top flag that reports free too early would overwrite a word; one that reports too late would lose capacity. It then drains the full stack with the request held, because a ready chain that only looks at registered occupancy would open a gap at every other pop. Random bursts of concurrent writes and pops are compared against a scoreboard. A reset taken with a word at the bottom must leave that word's bits visible, which a design that resets its data registers would fail.

// File: rtl/ft_stack_pkg.sv
package ft_stack_pkg;

  // Default geometry of the fall-through column.
  localparam int unsigned FTS_DEPTH = 62;
  localparam int unsigned FTS_WIDTH = 4;

  // Width of a counter able to hold 0..depth.
  function automatic int unsigned occ_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

endpackage

// File: rtl/ft_rst_sync.sv
module ft_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/ft_cell.sv
// One location of the fall-through column: an occupancy flag with reset,
// and a data register without reset, loaded only when a word is taken.
module ft_cell #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,   // word offered from above
  input  logic [WIDTH-1:0] up_data,
  input  logic             dn_ready,   // location below takes a word this edge
  output logic             up_ready,   // this location can take a word this edge
  output logic             held,
  output logic [WIDTH-1:0] word
);

  logic             held_q;
  logic             held_d;
  logic [WIDTH-1:0] word_q;
  logic             take;
  logic             leave;

  // Next-state logic
  always_comb begin
    leave    = held_q & dn_ready;
    up_ready = ~held_q | dn_ready;
    take     = up_valid & up_ready;
    held_d   = take | (held_q & ~leave);
  end

  // Control register: cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 1'b0;
    end else begin
      held_q <= held_d;
    end
  end

  // Data register: clock enable only, reset leaves contents intact
  always_ff @(posedge clk) begin
    if (take) begin
      word_q <= up_data;
    end
  end

  assign held = held_q;
  assign word = word_q;

endmodule

// File: rtl/ft_stack_status.sv
module ft_stack_status #(
  parameter int unsigned DEPTH = 62
) (
  input  logic             rst_sync_n,
  input  logic [DEPTH-1:0] held_vec,
  output logic             top_empty,
  output logic             bot_valid
);

  always_comb begin
    top_empty = rst_sync_n & ~held_vec[0];
    bot_valid = held_vec[DEPTH-1];
  end

endmodule

// File: rtl/ft_stack_core.sv
module ft_stack_core
  import ft_stack_pkg::*;
#(
  parameter int unsigned DEPTH = FTS_DEPTH,
  parameter int unsigned WIDTH = FTS_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic             top_empty,
  input  logic             rd_req,
  output logic             bot_valid,
  output logic [WIDTH-1:0] bot_data
);

  localparam int unsigned LAST = DEPTH - 1;

  logic             rst_sync_n;
  logic             wr_take;
  logic [DEPTH-1:0] stg_valid;
  logic [DEPTH-1:0] stg_ready;
  logic [WIDTH-1:0] stg_data [DEPTH];

  ft_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // The top accepts only when its location is free.
  assign wr_take = wr_req & top_empty;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic             in_valid;
    logic [WIDTH-1:0] in_data;
    logic             out_ready;

    if (i == 0) begin : g_top
      assign in_valid = wr_take;
      assign in_data  = wr_data;
    end else begin : g_inner
      assign in_valid = stg_valid[i-1];
      assign in_data  = stg_data[i-1];
    end

    if (i == LAST) begin : g_bottom
      assign out_ready = rd_req;
    end else begin : g_mid
      assign out_ready = stg_ready[i+1];
    end

    ft_cell #(
      .WIDTH (WIDTH)
    ) u_cell (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .up_valid (in_valid),
      .up_data  (in_data),
      .dn_ready (out_ready),
      .up_ready (stg_ready[i]),
      .held     (stg_valid[i]),
      .word     (stg_data[i])
    );
  end

  ft_stack_status #(
    .DEPTH (DEPTH)
  ) u_status (
    .rst_sync_n (rst_sync_n),
    .held_vec   (stg_valid),
    .top_empty  (top_empty),
    .bot_valid  (bot_valid)
  );

  assign bot_data = stg_data[LAST];

endmodule

// File: rtl/ft_stack_core_chk.sv
module ft_stack_core_chk #(
  parameter int unsigned DEPTH = 62,
  parameter int unsigned WIDTH = 4
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             wr_req,
  input logic             top_empty,
  input logic             rd_req,
  input logic             bot_valid,
  input logic [WIDTH-1:0] bot_data,
  input logic [DEPTH-1:0] valid_vec
);

  localparam int unsigned OCC_W = $clog2(DEPTH + 1);

  logic [OCC_W-1:0] occ_q;
  logic [OCC_W-1:0] occ_d;
  logic             acc;
  logic             pop;

  always_comb begin
    acc   = wr_req & top_empty;
    pop   = rd_req & bot_valid;
    occ_d = occ_q + OCC_W'(acc) - OCC_W'(pop);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      occ_q <= '0;
    end else begin
      occ_q <= occ_d;
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_sync_n |-> (!bot_valid && !top_empty));

  assert_top_taken_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_req && top_empty) |=> !top_empty);

  assert_fall_through_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bot_valid && valid_vec[DEPTH-2]) |=> bot_valid);

  assert_capacity_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (occ_q == OCC_W'(DEPTH)) |-> !top_empty);

  assert_bottom_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bot_valid && !rd_req) |=> (bot_valid && $stable(bot_data)));

  assert_no_loss_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $countones(valid_vec) == int'(occ_q));

endmodule

bind ft_stack_core ft_stack_core_chk #(
  .DEPTH (DEPTH),
  .WIDTH (WIDTH)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .wr_req     (wr_req),
  .top_empty  (top_empty),
  .rd_req     (rd_req),
  .bot_valid  (bot_valid),
  .bot_data   (bot_data),
  .valid_vec  (stg_valid)
);

// File: tb/ft_stack_core_bench.sv
module ft_stack_core_bench;

  localparam int DEPTH = 62;
  localparam int WIDTH = 4;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wr_req;
  logic [WIDTH-1:0] wr_data;
  logic             top_empty;
  logic             rd_req;
  logic             bot_valid;
  logic [WIDTH-1:0] bot_data;

  int n_chk  = 0;
  int n_fail = 0;
  int n_acc  = 0;
  int n_pop  = 0;
  logic [WIDTH-1:0] sb [$];

  always #5 clk = ~clk;

  ft_stack_core u_ft_stack_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_data   (wr_data),
    .top_empty (top_empty),
    .rd_req    (rd_req),
    .bot_valid (bot_valid),
    .bot_data  (bot_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, model the coming rising edge, advance.
  task automatic step(input bit w, input logic [WIDTH-1:0] d, input bit r);
    logic [WIDTH-1:0] exp_w;
    wr_req  = w;
    wr_data = d;
    rd_req  = r;
    #1;
    if (w && top_empty) begin
      sb.push_back(d);
      n_acc++;
    end
    if (r && bot_valid) begin
      n_pop++;
      if (sb.size() == 0) begin
        check(1'b0, "R8 pop with empty model", int'(bot_data), -1);
      end else begin
        exp_w = sb.pop_front();
        check(bot_data == exp_w, "R8 order", int'(bot_data), int'(exp_w));
      end
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n  = 1'b0;
    wr_req = 1'b0;
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
    check(top_empty == 1'b0, "R1 top_empty in reset", int'(top_empty), 0);
    check(bot_valid == 1'b0, "R1 bot_valid in reset", int'(bot_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    sb.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wr_req  = 1'b0;
    wr_data = '0;
    rd_req  = 1'b0;
    @(negedge clk);
    do_reset();
    check(top_empty == 1'b1, "R1 top_empty after release", int'(top_empty), 1);
    check(bot_valid == 1'b0, "R1 bot_valid after release", int'(bot_valid), 0);

    // R4: latency of a single word through the empty column
    step(1'b1, 4'hA, 1'b0);
    check(top_empty == 1'b0, "R2 top taken after write", int'(top_empty), 0);
    for (int n = 1; n <= DEPTH; n++) begin
      check(bot_valid == (n == DEPTH), "R4 fall-through latency", int'(bot_valid), int'(n == DEPTH));
      if (n < DEPTH) step(1'b0, '0, 1'b0);
    end

    // R7: hold without request, then a single delivery
    for (int k = 0; k < 3; k++) begin
      step(1'b0, '0, 1'b0);
      check(bot_valid && bot_data == 4'hA, "R7 hold", int'(bot_data), 10);
    end
    n_pop = 0;
    step(1'b0, '0, 1'b1);
    check(n_pop == 1, "R7 pop taken", n_pop, 1);
    check(bot_valid == 1'b0, "R7 delivered once", int'(bot_valid), 0);

    // R10: requests on an empty bottom do nothing, later word still arrives
    n_pop = 0;
    for (int k = 0; k < 5; k++) step(1'b0, '0, 1'b1);
    check(n_pop == 0, "R10 no pop while empty", n_pop, 0);
    step(1'b1, 4'h3, 1'b1);
    for (int k = 0; k < 80 && sb.size() != 0; k++) step(1'b0, '0, 1'b1);
    check(n_pop == 1 && sb.size() == 0, "R10 late word delivered", n_pop, 1);

    // R6 and R3: fill with writes held high
    n_acc = 0;
    for (int k = 0; k < 200; k++) step(1'b1, WIDTH'(n_acc), 1'b0);
    check(n_acc == DEPTH, "R6 capacity", n_acc, DEPTH);
    check(top_empty == 1'b0, "R6 full top", int'(top_empty), 0);

    // R5: drain a full column with the request held
    for (int k = 0; k < DEPTH; k++) begin
      check(bot_valid == 1'b1, "R5 back-to-back pop", int'(bot_valid), 1);
      step(1'b0, '0, 1'b1);
    end
    check(bot_valid == 1'b0, "R3 ignored writes added nothing", int'(bot_valid), 0);
    check(sb.size() == 0, "R3 model drained", sb.size(), 0);

    // R9: reset keeps the data bits
    step(1'b1, 4'h5, 1'b0);
    for (int k = 0; k < DEPTH; k++) step(1'b0, '0, 1'b0);
    check(bot_valid == 1'b1, "R9 word at bottom before reset", int'(bot_valid), 1);
    do_reset();
    check(bot_valid == 1'b0, "R9 control cleared", int'(bot_valid), 0);
    check(bot_data == 4'h5, "R9 data kept", int'(bot_data), 5);

    // R8: random concurrent traffic, swept over write and pop densities
    for (int ph = 0; ph < 4; ph++) begin
      for (int k = 0; k < 800; k++) begin
        step(($urandom % 4) <= ph, WIDTH'($urandom), ($urandom % 4) <= (3 - ph));
      end
    end
    for (int k = 0; k < 300 && sb.size() != 0; k++) step(1'b0, '0, 1'b1);
    check(sb.size() == 0, "R8 all words delivered", sb.size(), 0);
    check(bot_valid == 1'b0, "R8 no extra words", int'(bot_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule